// File: doc/BRIEF.md
# Two-Stage Decoupled Branch Pipeline

This block is a small in-order core cut into two stages. The front stage looks up the instruction at the current program counter, decodes it, and reads its source operands from the register file. It then pushes a decoded template, tagged with the PC it was fetched from, into a two-slot queue. The back stage takes the oldest template from the queue. For an add it writes the sum into the register file. For a branch-if-zero it tests the operand value that was captured at decode and redirects the front stage when that value is zero.

Both stages may act in the same cycle. When the back stage takes a branch, the queue is emptied of everything younger than the branch. In that same cycle the front stage is steered to the branch target, so the target instruction lands in the queue at once as its only entry. A front-stage instruction whose source register is the destination of an add still waiting in the queue is held back until that add has written the register file. There is no bypass path. The instruction memory sits outside the block and answers combinationally to `imem_addr`. The `exec_go` input lets the back stage advance; while it is low the queue can fill up.

Top module: `dbp_core`

## Requirements
- R1: The queue holds at most two templates. When the queue is full, the front stage enqueues only if the back stage dequeues in the same cycle.
- R2: An instruction word is 17 bits. Bits [16:15] hold the opcode: 01 is add, 10 is branch-if-zero, and 00 and 11 are no-ops. For add, the destination is in [14:10], source 1 in [9:5] and source 2 in [4:0]. For branch-if-zero, the tested register is in [14:10] and the target PC is in [9:0].
- R3: Each fetch that is not redirected advances the PC by one. `fe_valid` and `fe_pc` report each fetch, with its PC, one cycle after it happens.
- R4: An add reads both operands at fetch. When it executes it writes their 32-bit sum to its destination register. `ex_valid`, `ex_pc`, `wr_en`, `wr_addr` and `wr_data` report this one cycle after execution.
- R5: A branch-if-zero whose captured value is zero is taken and is reported with `ex_taken`. The younger templates in the queue are discarded: they never execute and never write.
- R6: When a taken branch executes, the front stage fetches the target in the same cycle. That template becomes the only queue entry, tagged with the target PC, and the PC becomes target+1.
- R7: A branch that is not taken only dequeues itself. The front stage keeps fetching in the same cycle unless it is stalled.
- R8: The front stage stalls, and the PC holds, while a source register of the instruction at the PC equals the destination of an add in the queue. A register write becomes visible to fetch reads in the following cycle.
- R9: Both no-op opcodes pass through execute with `ex_valid` high and `wr_en` low.
- R10: While `exec_go` is low, nothing executes and the queued templates are kept.
- R11: Reset clears the queue, sets the PC to 0, drives all report outputs low and loads each register i with the value i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_go | input | 1 | Lets the back stage execute the queue head |
| imem_addr | output | 10 | PC of the instruction being fetched (the branch target on a redirect) |
| imem_data | input | 17 | Instruction word at `imem_addr` |
| fe_valid | output | 1 | A fetch took place in the previous cycle |
| fe_pc | output | 10 | PC of that fetch |
| ex_valid | output | 1 | A template executed in the previous cycle |
| ex_pc | output | 10 | PC tag of that template |
| ex_taken | output | 1 | That template was a taken branch |
| wr_en | output | 1 | That template wrote the register file |
| wr_addr | output | 5 | Register written |
| wr_data | output | 32 | Value written |

## Verification
Two collisions are exercised: a taken branch in execute in the same cycle as the fetch of its target, and a dequeue from a full queue in the same cycle as a fresh enqueue. Both are set up by holding `exec_go` low until the queue has filled, then releasing it. The bench then checks the exact cycle and PC tag of each fetch and execute report. It also checks that the wrong-path add never wrote, by reading its destination register through a later add. Register hazards across a not-taken branch are judged by the value that the dependent add finally writes.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int PC_W    = 10;
  localparam int DEPTH   = 2;
  localparam int RA_W    = $clog2(NREG);
  localparam int BODY_W  = (2 * RA_W > PC_W) ? 2 * RA_W : PC_W;
  localparam int INSTR_W = 2 + RA_W + BODY_W;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {
    OPC_NOP0 = 2'b00,
    OPC_ADD  = 2'b01,
    OPC_BZ   = 2'b10,
    OPC_NOP3 = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    TK_NOP = 2'd0,
    TK_ADD = 2'd1,
    TK_BZ  = 2'd2
  } tkind_e;

  typedef struct packed {
    tkind_e            kind;
    logic [RA_W-1:0]   rd;
    logic [XLEN-1:0]   a;
    logic [XLEN-1:0]   b;
    logic [PC_W-1:0]   tgt;
    logic [PC_W-1:0]   pc;
  } tmpl_t;
endpackage

// File: rtl/dbp_regfile.sv
module dbp_regfile #(
  parameter int N  = 32,
  parameter int W  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  // seeded with the index so that operands are distinct after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= W'(i);
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  // no write-through: a write is seen by reads one cycle later
  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/dbp_decode.sv
module dbp_decode
  import dbp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    pc,
  input  logic [XLEN-1:0]    v1,
  input  logic [XLEN-1:0]    v2,
  output logic [RA_W-1:0]    ra1,
  output logic [RA_W-1:0]    ra2,
  output logic               use1,
  output logic               use2,
  output tmpl_t              tmpl
);
  opc_e            opc;
  logic [RA_W-1:0] f_a;
  logic [RA_W-1:0] f_s1;
  logic [RA_W-1:0] f_s2;
  logic [PC_W-1:0] f_tgt;

  assign opc   = opc_e'(instr[INSTR_W-1 -: 2]);
  assign f_a   = instr[BODY_W +: RA_W];
  assign f_s1  = instr[RA_W +: RA_W];
  assign f_s2  = instr[0 +: RA_W];
  assign f_tgt = instr[0 +: PC_W];

  // register addresses depend only on the word, kept apart from the operand path
  assign ra1  = (opc == OPC_BZ) ? f_a : f_s1;
  assign ra2  = f_s2;
  assign use1 = (opc == OPC_ADD) || (opc == OPC_BZ);
  assign use2 = (opc == OPC_ADD);

  always_comb begin
    tmpl      = '0;
    tmpl.kind = TK_NOP;
    tmpl.pc   = pc;
    case (opc)
      OPC_ADD: begin
        tmpl.kind = TK_ADD;
        tmpl.rd   = f_a;
        tmpl.a    = v1;
        tmpl.b    = v2;
      end
      OPC_BZ: begin
        tmpl.kind = TK_BZ;
        tmpl.a    = v1;
        tmpl.tgt  = f_tgt;
      end
      default: tmpl.kind = TK_NOP;
    endcase
  end
endmodule

// File: rtl/dbp_hazard.sv
module dbp_hazard
  import dbp_pkg::*;
#(
  parameter int D = 2
) (
  input  tmpl_t [D-1:0]   ents,
  input  logic  [D-1:0]   vld,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  input  logic            use1,
  input  logic            use2,
  output logic            stall
);
  logic [D-1:0] hit;

  for (genvar i = 0; i < D; i++) begin : g_cmp
    assign hit[i] = vld[i] && (ents[i].kind == TK_ADD) &&
                    ((use1 && ents[i].rd == ra1) || (use2 && ents[i].rd == ra2));
  end

  assign stall = |hit;
endmodule

// File: rtl/dbp_tbuf.sv
module dbp_tbuf
  import dbp_pkg::*;
#(
  parameter int D  = 2,
  parameter int CW = $clog2(D + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_one,
  input  logic            enq,
  input  logic            deq,
  input  tmpl_t           din,
  output tmpl_t [D-1:0]   ents,
  output logic  [D-1:0]   vld,
  output logic [CW-1:0]   cnt,
  output logic            full
);
  tmpl_t [D-1:0] ents_q, nxt_e;
  logic [CW-1:0] cnt_q, nxt_c;

  always_comb begin
    nxt_e = ents_q;
    nxt_c = cnt_q;
    if (load_one) begin
      nxt_e[0] = din;
      nxt_c    = CW'(1);
    end else begin
      if (deq) begin
        for (int i = 0; i < D - 1; i++) nxt_e[i] = ents_q[i+1];
        nxt_c = cnt_q - CW'(1);
      end
      if (enq) begin
        nxt_e[int'(nxt_c)] = din;
        nxt_c = nxt_c + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ents_q <= '0;
      cnt_q  <= '0;
    end else begin
      ents_q <= nxt_e;
      cnt_q  <= nxt_c;
    end
  end

  for (genvar i = 0; i < D; i++) begin : g_vld
    assign vld[i] = (cnt_q > CW'(i));
  end

  assign ents = ents_q;
  assign cnt  = cnt_q;
  assign full = (cnt_q == CW'(D));
endmodule

// File: rtl/dbp_exec.sv
module dbp_exec
  import dbp_pkg::*;
(
  input  tmpl_t            head,
  input  logic             head_vld,
  input  logic             go,
  output logic             fire,
  output logic             taken,
  output logic             we,
  output logic [RA_W-1:0]  wa,
  output logic [XLEN-1:0]  wd,
  output logic [PC_W-1:0]  tgt
);
  assign fire  = head_vld && go;
  assign taken = fire && (head.kind == TK_BZ) && (head.a == '0);
  assign we    = fire && (head.kind == TK_ADD);
  assign wa    = head.rd;
  assign wd    = head.a + head.b;
  assign tgt   = head.tgt;
endmodule

// File: rtl/dbp_core.sv
module dbp_core
  import dbp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               exec_go,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic               fe_valid,
  output logic [PC_W-1:0]    fe_pc,
  output logic               ex_valid,
  output logic [PC_W-1:0]    ex_pc,
  output logic               ex_taken,
  output logic               wr_en,
  output logic [RA_W-1:0]    wr_addr,
  output logic [XLEN-1:0]    wr_data
);
  logic [PC_W-1:0]  pc_q;
  logic [RA_W-1:0]  ra1, ra2;
  logic             use1, use2;
  logic [XLEN-1:0]  v1, v2;
  tmpl_t            dec_t;
  tmpl_t [DEPTH-1:0] ents;
  logic [DEPTH-1:0] vld;
  logic [CNT_W-1:0] buf_cnt;
  logic             buf_full;
  logic             stall;
  logic             ex_fire, redirect, x_we;
  logic [RA_W-1:0]  x_wa;
  logic [XLEN-1:0]  x_wd;
  logic [PC_W-1:0]  x_tgt;
  logic             fetch_fire;

  dbp_regfile #(.N(NREG), .W(XLEN), .AW(RA_W)) u_rf (
    .clk(clk), .rst(rst), .ra1(ra1), .ra2(ra2), .rd1(v1), .rd2(v2),
    .we(x_we), .wa(x_wa), .wd(x_wd)
  );

  dbp_decode u_dec (
    .instr(imem_data), .pc(imem_addr), .v1(v1), .v2(v2),
    .ra1(ra1), .ra2(ra2), .use1(use1), .use2(use2), .tmpl(dec_t)
  );

  dbp_hazard #(.D(DEPTH)) u_haz (
    .ents(ents), .vld(vld), .ra1(ra1), .ra2(ra2),
    .use1(use1), .use2(use2), .stall(stall)
  );

  dbp_exec u_ex (
    .head(ents[0]), .head_vld(vld[0]), .go(exec_go), .fire(ex_fire),
    .taken(redirect), .we(x_we), .wa(x_wa), .wd(x_wd), .tgt(x_tgt)
  );

  // a taken branch steers this cycle's fetch to its target
  assign imem_addr  = redirect ? x_tgt : pc_q;
  assign fetch_fire = redirect || (!stall && (!buf_full || ex_fire));

  dbp_tbuf #(.D(DEPTH), .CW(CNT_W)) u_buf (
    .clk(clk), .rst(rst),
    .load_one(redirect),
    .enq(fetch_fire && !redirect),
    .deq(ex_fire && !redirect),
    .din(dec_t),
    .ents(ents), .vld(vld), .cnt(buf_cnt), .full(buf_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      fe_valid <= 1'b0;
      fe_pc    <= '0;
      ex_valid <= 1'b0;
      ex_pc    <= '0;
      ex_taken <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (fetch_fire) pc_q <= imem_addr + PC_W'(1);
      fe_valid <= fetch_fire;
      fe_pc    <= imem_addr;
      ex_valid <= ex_fire;
      ex_pc    <= ents[0].pc;
      ex_taken <= redirect;
      wr_en    <= x_we;
      wr_addr  <= x_wa;
      wr_data  <= x_wd;
    end
  end
endmodule

// File: rtl/dbp_core_chk.sv
module dbp_core_chk
  import dbp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             redirect,
  input logic             fetch_fire,
  input logic             stall,
  input logic             ex_fire,
  input logic [CNT_W-1:0] buf_cnt,
  input logic [PC_W-1:0]  pc_q,
  input logic [PC_W-1:0]  x_tgt,
  input logic             fe_valid,
  input logic [PC_W-1:0]  fe_pc,
  input logic             ex_valid,
  input logic             ex_taken,
  input logic             wr_en
);
  // R1
  occupancy_max_chk: assert property (@(posedge clk) disable iff (rst)
    buf_cnt <= CNT_W'(DEPTH));

  // R1
  full_no_enq_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_cnt == CNT_W'(DEPTH) && !ex_fire) |=> !fe_valid);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_fire && !redirect) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  // R6
  redirect_land_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (fe_valid && ex_taken && buf_cnt == CNT_W'(1) &&
                  fe_pc == $past(x_tgt) && pc_q == PC_W'($past(x_tgt) + 1'b1)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !redirect) |=> (!fe_valid && pc_q == $past(pc_q)));

  // R5
  write_not_branch_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ex_valid && !ex_taken));
endmodule

bind dbp_core dbp_core_chk chk_i (
  .clk(clk), .rst(rst), .redirect(redirect), .fetch_fire(fetch_fire),
  .stall(stall), .ex_fire(ex_fire), .buf_cnt(buf_cnt), .pc_q(pc_q),
  .x_tgt(x_tgt), .fe_valid(fe_valid), .fe_pc(fe_pc), .ex_valid(ex_valid),
  .ex_taken(ex_taken), .wr_en(wr_en)
);

// File: tb/dbp_core_tb_top.sv
`timescale 1ns/1ps
module dbp_core_tb_top;
  import dbp_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst = 1'b1;
  logic               exec_go = 1'b0;
  logic [PC_W-1:0]    imem_addr;
  logic [INSTR_W-1:0] imem_data;
  logic               fe_valid, ex_valid, ex_taken, wr_en;
  logic [PC_W-1:0]    fe_pc, ex_pc;
  logic [RA_W-1:0]    wr_addr;
  logic [XLEN-1:0]    wr_data;

  logic [INSTR_W-1:0] imem [0:(1<<PC_W)-1];
  assign imem_data = imem[imem_addr];

  dbp_core dut_i (
    .clk(clk), .rst(rst), .exec_go(exec_go), .imem_addr(imem_addr),
    .imem_data(imem_data), .fe_valid(fe_valid), .fe_pc(fe_pc),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  localparam int LOGN = 16;
  logic lf_v [LOGN];
  int   lf_pc[LOGN];
  logic lx_v [LOGN];
  int   lx_pc[LOGN];
  logic lx_tk[LOGN];
  logic lx_we[LOGN];
  int   lx_wa[LOGN];
  int   lx_wd[LOGN];

  // encodings per R2
  function automatic logic [16:0] i_add(int rd, int s1, int s2);
    return {2'b01, 5'(rd), 5'(s1), 5'(s2)};
  endfunction
  function automatic logic [16:0] i_bz(int c, int t);
    return {2'b10, 5'(c), 10'(t)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < (1 << PC_W); i++) imem[i] = '0;
  endtask

  // reset, then run with execute held off for the first `hold` cycles;
  // log[i] is the report after the (i+1)-th edge past reset
  task automatic boot_run(int hold);
    @(negedge clk);
    rst = 1'b1;
    exec_go = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(fe_valid == 0 && ex_valid == 0 && wr_en == 0, "R11", "report outputs in reset",
        {fe_valid, ex_valid, wr_en}, 0);
    chk(imem_addr == 0, "R11", "pc in reset", imem_addr, 0);
    rst = 1'b0;
    exec_go = (hold == 0);
    for (int i = 0; i < LOGN; i++) begin
      @(posedge clk);
      @(negedge clk);
      lf_v[i] = fe_valid;  lf_pc[i] = int'(fe_pc);
      lx_v[i] = ex_valid;  lx_pc[i] = int'(ex_pc);
      lx_tk[i] = ex_taken; lx_we[i] = wr_en;
      lx_wa[i] = int'(wr_addr); lx_wd[i] = int'(wr_data);
      exec_go = ((i + 1) >= hold);
    end
  endtask

  task automatic ck_fe(int i, bit v, int pc, string req);
    chk(lf_v[i] == v, req, $sformatf("fetch valid @%0d", i), lf_v[i], v);
    if (v) chk(lf_pc[i] == pc, req, $sformatf("fetch pc @%0d", i), lf_pc[i], pc);
  endtask

  task automatic ck_ex(int i, bit v, int pc, bit tk, bit we, int wa, int wd, string req);
    chk(lx_v[i] == v, req, $sformatf("exec valid @%0d", i), lx_v[i], v);
    if (v) begin
      chk(lx_pc[i] == pc, req, $sformatf("exec pc @%0d", i), lx_pc[i], pc);
      chk(lx_tk[i] == tk, req, $sformatf("taken @%0d", i), lx_tk[i], tk);
      chk(lx_we[i] == we, req, $sformatf("write en @%0d", i), lx_we[i], we);
      if (we) begin
        chk(lx_wa[i] == wa, req, $sformatf("write reg @%0d", i), lx_wa[i], wa);
        chk(lx_wd[i] == wd, req, $sformatf("write data @%0d", i), lx_wd[i], wd);
      end
    end
  endtask

  // R3 R4 R11: independent adds stream one per cycle
  task automatic t_straight();
    clr_mem();
    imem[0] = i_add(3, 1, 2);
    imem[1] = i_add(6, 4, 5);
    imem[2] = i_add(9, 7, 8);
    boot_run(0);
    ck_fe(0, 1, 0, "R3");
    ck_fe(1, 1, 1, "R3");
    ck_fe(2, 1, 2, "R3");
    ck_ex(0, 0, 0, 0, 0, 0, 0, "R4");
    ck_ex(1, 1, 0, 0, 1, 3, 3, "R11");
    ck_ex(2, 1, 1, 0, 1, 6, 9, "R4");
    ck_ex(3, 1, 2, 0, 1, 9, 15, "R4");
  endtask

  // R8: dependent add waits for the write, then sees the new value
  task automatic t_raw();
    clr_mem();
    imem[0] = i_add(3, 5, 6);
    imem[1] = i_add(4, 3, 3);
    boot_run(0);
    ck_fe(0, 1, 0, "R8");
    ck_fe(1, 0, 0, "R8");
    ck_fe(2, 1, 1, "R8");
    ck_ex(1, 1, 0, 0, 1, 3, 11, "R4");
    ck_ex(2, 0, 0, 0, 0, 0, 0, "R8");
    ck_ex(3, 1, 1, 0, 1, 4, 22, "R8");
  endtask

  // R1 R9 R10: fill with execute held, then enqueue alongside dequeue
  task automatic t_full();
    clr_mem();
    imem[0] = i_add(3, 1, 2);
    imem[1] = i_add(6, 4, 5);
    imem[2] = i_add(9, 7, 8);
    imem[3] = {2'b11, 15'h7fff};
    imem[4] = '0;
    boot_run(3);
    ck_fe(0, 1, 0, "R1");
    ck_fe(1, 1, 1, "R1");
    ck_fe(2, 0, 0, "R1");
    ck_fe(3, 1, 2, "R1");
    ck_ex(0, 0, 0, 0, 0, 0, 0, "R10");
    ck_ex(2, 0, 0, 0, 0, 0, 0, "R10");
    ck_ex(3, 1, 0, 0, 1, 3, 3, "R10");
    ck_ex(4, 1, 1, 0, 1, 6, 9, "R1");
    ck_ex(5, 1, 2, 0, 1, 9, 15, "R1");
    ck_ex(6, 1, 3, 0, 0, 0, 0, "R9");
    ck_ex(7, 1, 4, 0, 0, 0, 0, "R9");
  endtask

  // R5 R6: taken branch with a younger add queued behind it
  task automatic t_taken();
    int seen;
    clr_mem();
    imem[0]  = i_bz(0, 20);
    imem[1]  = i_add(7, 2, 2);
    imem[20] = i_add(9, 4, 7);
    boot_run(3);
    ck_fe(1, 1, 1, "R5");
    ck_ex(3, 1, 0, 1, 0, 0, 0, "R5");
    ck_fe(3, 1, 20, "R6");
    ck_fe(4, 1, 21, "R6");
    ck_ex(4, 1, 20, 0, 1, 9, 11, "R5");
    ck_ex(5, 1, 21, 0, 0, 0, 0, "R6");
    seen = 0;
    for (int i = 0; i < LOGN; i++)
      if (lx_v[i] && (lx_pc[i] == 1 || (lx_we[i] && lx_wa[i] == 7))) seen++;
    chk(seen == 0, "R5", "wrong-path template executed", seen, 0);
  endtask

  // R7: not-taken branch, fetch continues in the same cycle
  task automatic t_nottaken();
    clr_mem();
    imem[0] = i_bz(1, 20);
    imem[1] = i_add(3, 1, 2);
    boot_run(0);
    ck_fe(1, 1, 1, "R7");
    ck_ex(1, 1, 0, 0, 0, 0, 0, "R7");
    ck_ex(2, 1, 1, 0, 1, 3, 3, "R7");
  endtask

  // R7 R8: not-taken branch dequeues while fetch stalls on a queued add
  task automatic t_nt_stall();
    clr_mem();
    imem[0] = i_bz(2, 20);
    imem[1] = i_add(5, 1, 1);
    imem[2] = i_add(6, 5, 0);
    boot_run(3);
    ck_ex(3, 1, 0, 0, 0, 0, 0, "R7");
    ck_fe(3, 0, 0, "R7");
    ck_fe(4, 0, 0, "R8");
    ck_ex(4, 1, 1, 0, 1, 5, 2, "R8");
    ck_fe(5, 1, 2, "R8");
    ck_ex(6, 1, 2, 0, 1, 6, 2, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_straight();
    t_raw();
    t_full();
    t_taken();
    t_nottaken();
    t_nt_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule